// File: doc/BRIEF.md
# SPI Display Command/Data Serializer

This block is a write-only SPI master that feeds a display controller. A host hands it bytes over a valid/ready stream. Each byte carries a flag that marks it as a controller command or as pixel/parameter data. The block shifts every byte out on a single serial data line, most significant bit first. The line is framed by an active-low chip select, and the serial clock idles low (SPI mode 0).

Two framing modes are available. In four-wire mode, a separate data/command pin carries the flag for the whole byte. In three-wire mode, that pin stays low and the flag is sent as one extra leading bit, so each frame is nine bits long. The serial clock period is a programmable even number of system clock cycles. Bytes that arrive while a burst is running follow on with no idle clock between them, and chip select stays low for the whole burst.

Back-pressure rules: `in_ready` is high whenever the block is idle. During a transfer it is high for exactly one cycle, the cycle in which the serial clock falls after the last bit of the current frame. A byte is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. A host that keeps `in_valid` asserted therefore gets seamless bursts. When `in_valid` is low in that one cycle, the burst ends.

Top module: `spi_disp_ser`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `in_ready` is 1.
- R2: `cs_n` is 0 at every rising edge of `sclk`, and `sclk` never goes high while `cs_n` is 1. When the stream is empty after the last bit, `cs_n` returns to 1, and no partial frame is left.
- R3: Each byte is sent as 8 bits, most significant bit first. A bit is captured on the rising edge of `sclk`.
- R4: Mode 0 timing applies. `sclk` idles low, and `mosi` does not change while `sclk` is high.
- R5: In four-wire mode (`three_wire` = 0), `dc` is 1 for a command byte and 0 for a data byte. It stays constant across all 8 bits of the byte.
- R6: In three-wire mode (`three_wire` = 1), every frame is 9 bits. The first bit is the flag (1 = command, 0 = data), and the 8 data bits follow. `dc` stays 0 while `cs_n` is 0.
- R7: With effective divisor D, `sclk` is high for D/2 system cycles and low for D/2 system cycles. Successive rising edges within a burst are D cycles apart. The divisor is taken when a burst starts.
- R8: An odd `clk_div` value is treated as the next even value. Zero is treated as 2.
- R9: Bytes accepted during a burst follow the previous frame with no idle clock. The spacing of `sclk` rising edges across a byte boundary equals the spacing inside a byte, and the whole burst lies in one `cs_n` low window.
- R10: `three_wire` is sampled only when a burst starts. A change during a burst has no effect until `cs_n` has returned high.
- R11: While `cs_n` is 0, `in_ready` is high for exactly one cycle per frame, at the falling `sclk` edge that ends the frame's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Serial clock divisor in system cycles (rounded up to even, minimum 2) |
| three_wire | input | 1 | 1 = flag sent as leading ninth bit, 0 = flag on `dc` pin |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | DATA_W | Byte to send |
| in_cmd | input | 1 | 1 = command byte, 0 = data byte |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the display |
| cs_n | output | 1 | Active-low chip select |
| dc | output | 1 | Data/command pin (four-wire mode) |

## Verification
The critical coincidence is the end of a frame meeting the acceptance of the next byte. In one cycle the last bit's falling clock edge must reload the shifter, update `dc`, and keep chip select low. The bench provokes this by holding `in_valid` high across multi-byte bursts at several divisors. It judges the result at the pins by checking that the rising-edge spacing stays constant across byte boundaries, that each burst uses only one chip-select window, and that no partial frame is left. A second overlap comes from flipping the mode input in the middle of a burst. That case passes only if every frame of the running burst keeps the mode that was latched at its start.

// File: rtl/spi_disp_pkg.sv
package spi_disp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } ser_state_e;
endpackage

// File: rtl/spi_disp_divnorm.sv
module spi_disp_divnorm #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_raw,
  output logic [DIV_W-1:0] half_cnt
);
  logic [DIV_W:0] sum;
  // half period = ceil(div/2): odd values round up to the next even divisor
  always_comb begin
    sum = {1'b0, div_raw} + {{DIV_W{1'b0}}, 1'b1};
    if (div_raw == '0) half_cnt = {{(DIV_W-1){1'b0}}, 1'b1};
    else               half_cnt = sum[DIV_W:1];
  end
endmodule

// File: rtl/spi_disp_tick.sv
module spi_disp_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cnt,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_cnt - {{(DIV_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  assert_tick_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half_cnt));
endmodule

// File: rtl/spi_disp_shreg.sv
module spi_disp_shreg #(
  parameter int FRAME_W = 9,
  parameter int BCNT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] frame,
  input  logic [BCNT_W-1:0]  len_m1,
  output logic               mosi,
  output logic               last
);
  logic [FRAME_W-1:0] sr;
  logic [BCNT_W-1:0]  left;

  assign mosi = sr[FRAME_W-1];
  assign last = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= frame;
      left <= len_m1;
    end else if (shift) begin
      sr   <= {sr[FRAME_W-2:0], 1'b0};
      left <= left - {{(BCNT_W-1){1'b0}}, 1'b1};
    end
  end

  // R3: a shift never happens past the final bit
  assert_no_shift_past_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |-> (left != '0));
endmodule

// File: rtl/spi_disp_ser.sv
module spi_disp_ser #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              three_wire,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_cmd,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              dc
);
  import spi_disp_pkg::*;

  localparam int FRAME_W = DATA_W + 1;
  localparam int BCNT_W  = $clog2(FRAME_W);

  ser_state_e        state;
  logic              sclk_q, cs_q, dc_q, three_q;
  logic [DIV_W-1:0]  half_q, half_norm;
  logic              tick, last, fall_last, take, shift, three_sel;
  logic [FRAME_W-1:0] frame_next;
  logic [BCNT_W-1:0]  len_next;

  spi_disp_divnorm #(.DIV_W(DIV_W)) u_divnorm (
    .div_raw (clk_div),
    .half_cnt(half_norm)
  );

  spi_disp_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_XFER),
    .half_cnt(half_q),
    .tick    (tick)
  );

  // end of last bit: falling sclk edge with no bits remaining
  assign fall_last = (state == ST_XFER) && tick && sclk_q && last;
  assign in_ready  = (state == ST_IDLE) || fall_last;
  assign take      = in_valid && in_ready;
  assign shift     = (state == ST_XFER) && tick && sclk_q && !last;
  assign three_sel = (state == ST_IDLE) ? three_wire : three_q;

  always_comb begin
    if (three_sel) begin
      frame_next = {in_cmd, in_data};
      len_next   = BCNT_W'(DATA_W);
    end else begin
      frame_next = {in_data, 1'b0};
      len_next   = BCNT_W'(DATA_W - 1);
    end
  end

  spi_disp_shreg #(.FRAME_W(FRAME_W), .BCNT_W(BCNT_W)) u_shreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take),
    .shift (shift),
    .frame (frame_next),
    .len_m1(len_next),
    .mosi  (mosi),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      dc_q    <= 1'b0;
      three_q <= 1'b0;
      half_q  <= {{(DIV_W-1){1'b0}}, 1'b1};
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            state   <= ST_XFER;
            cs_q    <= 1'b0;
            three_q <= three_wire;
            half_q  <= half_norm;
            dc_q    <= three_wire ? 1'b0 : in_cmd;
          end
        end
        default: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (last) begin
                if (in_valid) begin
                  dc_q <= three_q ? 1'b0 : in_cmd;
                end else begin
                  state <= ST_IDLE;
                  cs_q  <= 1'b1;
                end
              end
            end
          end
        end
      endcase
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign dc   = dc_q;

  assert_sclk_only_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_q);
  assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(mosi));
  assert_dc_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(dc_q));
  assert_dc_low_3wire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && three_q) |-> !dc_q);
  assert_half_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> (half_q != '0));
  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && $past(!cs_q)) |-> $stable(three_q));
  assert_accept_selects_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !cs_q);
  assert_idle_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> in_ready);
endmodule

// File: tb/spi_disp_ser_bench.sv
module spi_disp_ser_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_div = 8'd2;
  logic       three_wire = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_cmd = 1'b0;
  logic       sclk, mosi, cs_n, dc;

  always #5 clk = ~clk;

  spi_disp_ser u_spi_disp_ser (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .three_wire(three_wire),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_cmd(in_cmd),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .dc(dc)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- pin monitor ----------------
  bit       exp_three = 0;
  int       exp_per = 2;
  int       cyc = 0, last_rise = 0;
  bit       have_rise = 0;
  logic     prev_sclk = 0, prev_cs = 1, prev_mosi = 0, fdc = 0;
  logic [8:0] sr = '0;
  int       nb = 0;
  int       bad_cs, bad_iv, bad_dc, bad_mosi, bad_idle, bad_part, cs_falls, rdy_x;
  logic [7:0] rx_d[$];
  logic       rx_f[$];
  logic [7:0] ex_d[$];
  logic       ex_f[$];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) cs_falls++;
      if (!cs_n && in_ready) rdy_x++;
      if (cs_n && sclk) bad_idle++;
      if (!cs_n && exp_three && dc) bad_dc++;
      if (prev_sclk && sclk && mosi != prev_mosi) bad_mosi++;
      if (!prev_sclk && sclk) begin
        if (cs_n) bad_cs++;
        if (have_rise && (cyc - last_rise) != exp_per) bad_iv++;
        have_rise = 1;
        last_rise = cyc;
        if (nb == 0) fdc = dc;
        else if (!exp_three && dc != fdc) bad_dc++;
        sr = {sr[7:0], mosi};
        nb++;
        if (nb == (exp_three ? 9 : 8)) begin
          rx_d.push_back(sr[7:0]);
          rx_f.push_back(exp_three ? sr[8] : fdc);
          nb = 0;
        end
      end
      if (cs_n) begin
        if (nb != 0) bad_part++;
        nb = 0;
        have_rise = 0;
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
    prev_mosi = mosi;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- helpers ----------------
  task automatic clear_mon(input bit three, input int per);
    exp_three = three;
    exp_per = per;
    bad_cs = 0; bad_iv = 0; bad_dc = 0; bad_mosi = 0;
    bad_idle = 0; bad_part = 0; cs_falls = 0; rdy_x = 0;
    rx_d.delete(); rx_f.delete(); ex_d.delete(); ex_f.delete();
  endtask

  task automatic push(input logic [7:0] b, input logic f);
    in_valid = 1'b1;
    in_data  = b;
    in_cmd   = f;
    ex_d.push_back(b);
    ex_f.push_back(f);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic end_burst();
    in_valid = 1'b0;
    while (!cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_frames(input string req);
    chk(rx_d.size() == ex_d.size(), req, rx_d.size(), ex_d.size());
    for (int i = 0; i < ex_d.size() && i < rx_d.size(); i++) begin
      chk(rx_d[i] == ex_d[i], {req, " byte"}, rx_d[i], ex_d[i]);
      chk(rx_f[i] == ex_f[i], {req, " flag"}, rx_f[i], ex_f[i]);
    end
  endtask

  task automatic common_pins();
    chk(bad_cs == 0,   "R2 clk while deselected", bad_cs, 0);
    chk(bad_idle == 0, "R2 sclk high idle", bad_idle, 0);
    chk(bad_part == 0, "R2 partial frame", bad_part, 0);
    chk(cs_n == 1'b1,  "R2 cs released", cs_n, 1);
    chk(bad_mosi == 0, "R4 mosi moved while sclk high", bad_mosi, 0);
    chk(sclk == 1'b0,  "R4 sclk idle low", sclk, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(cs_n == 1'b1,     "R1 cs_n", cs_n, 1);
    chk(sclk == 1'b0,     "R1 sclk", sclk, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
  endtask

  task automatic t_four_wire_burst();
    clear_mon(0, 2);
    clk_div = 8'd2; three_wire = 1'b0;
    push(8'hA5, 1); push(8'h3C, 0); push(8'hFF, 0); push(8'h01, 1);
    end_burst();
    cmp_frames("R3 R5 four-wire");
    chk(bad_dc == 0,   "R5 dc stable", bad_dc, 0);
    chk(bad_iv == 0,   "R9 edge spacing", bad_iv, 0);
    chk(cs_falls == 1, "R9 one cs window", cs_falls, 1);
    chk(rdy_x == 4,    "R11 ready pulses", rdy_x, 4);
    common_pins();
  endtask

  task automatic t_three_wire_burst();
    clear_mon(1, 4);
    clk_div = 8'd4; three_wire = 1'b1;
    push(8'h2C, 1); push(8'h80, 0); push(8'h7E, 0);
    end_burst();
    cmp_frames("R6 three-wire");
    chk(bad_dc == 0,   "R6 dc low", bad_dc, 0);
    chk(bad_iv == 0,   "R7 R9 period 4", bad_iv, 0);
    chk(cs_falls == 1, "R9 one cs window 3w", cs_falls, 1);
    chk(rdy_x == 3,    "R11 ready pulses 3w", rdy_x, 3);
    common_pins();
  endtask

  task automatic t_odd_div();
    clear_mon(0, 6);
    clk_div = 8'd5; three_wire = 1'b0;
    push(8'h96, 0); push(8'h69, 1);
    end_burst();
    cmp_frames("R8 odd divisor");
    chk(bad_iv == 0, "R8 R7 odd 5 -> period 6", bad_iv, 0);
    common_pins();
  endtask

  task automatic t_zero_div();
    clear_mon(0, 2);
    clk_div = 8'd0; three_wire = 1'b0;
    push(8'hC3, 0);
    end_burst();
    cmp_frames("R8 zero divisor");
    chk(bad_iv == 0, "R8 zero -> period 2", bad_iv, 0);
  endtask

  task automatic t_mode_midburst();
    clear_mon(0, 2);
    clk_div = 8'd2; three_wire = 1'b0;
    push(8'h11, 1);
    three_wire = 1'b1;
    push(8'h22, 0); push(8'h33, 1);
    end_burst();
    cmp_frames("R10 mode held in burst");
    chk(cs_falls == 1, "R10 single window", cs_falls, 1);
    clear_mon(1, 2);
    push(8'h44, 1);
    end_burst();
    cmp_frames("R10 mode after release");
  endtask

  task automatic t_gap();
    clear_mon(0, 8);
    clk_div = 8'd8; three_wire = 1'b0;
    push(8'h5A, 0);
    end_burst();
    chk(cs_n == 1'b1, "R2 released when empty", cs_n, 1);
    repeat (10) @(negedge clk);
    push(8'hE7, 1);
    end_burst();
    cmp_frames("R2 R3 separate bursts");
    chk(cs_falls == 2, "R2 two windows", cs_falls, 2);
    chk(bad_iv == 0,   "R7 period 8", bad_iv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_four_wire_burst();
    t_three_wire_burst();
    t_odd_div();
    t_zero_div();
    t_mode_midburst();
    t_gap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule